// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns four sleep-control bits from the processor status word into run and gate controls for the processor clock domain. It has one active mode and five sleep depths. Each deeper level stops more of the system. It drives a run enable for the processor core and three gated clocks: main, sub-main and auxiliary. It also drives enables for the DC generator of the digitally controlled oscillator (DCO) and for the crystal oscillator. The three gated clocks are derived from the block's own input clock.

An accepted interrupt wakes the system from any depth. The block pushes the current mode bits onto a small internal stack and clears them, so the handler runs in active mode. A return-from-interrupt pulse pops the saved bits, and the system goes back to the depth it left. Handlers may nest up to the stack depth.

Each gate enable passes through a latch that is open only while the clock is low. A gated clock therefore starts or stops only on whole pulses.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is held and right after it, the mode bits read 0000, the core runs, all three gated clocks toggle, both oscillator enables are high and the save stack is empty.
- R2: Mode bit 0 stops the core, bit 1 stops the oscillator, bit 2 disables the DCO generator and bit 3 stops the sub-main clock. A write pulse with no interrupt event loads `mode_bits_i` at the next edge.
- R3: Mode 0000 (active) runs the core and all three clocks, and enables both oscillators.
- R4: Mode 0001 (level 0) stops the core and the main clock. The sub-main and auxiliary clocks keep running and both oscillators stay enabled.
- R5: Mode 0101 (level 1) behaves as level 0, except that the DCO generator turns off when `dco_src_i` is low and stays on when it is high.
- R6: Mode 1001 (level 2) stops the core, the main clock and the sub-main clock. The DCO generator, the auxiliary clock and the crystal stay on.
- R7: Mode 1101 (level 3) leaves only the auxiliary clock and the crystal running. The DCO generator is off whatever the value of `dco_src_i`.
- R8: Mode 1111 (level 4) stops the core, all three clocks, the DCO generator and the crystal.
- R9: An interrupt-accept pulse clears the mode to 0000 at the next edge and pushes the prior mode. If a write arrives in the same cycle, the written value is pushed instead.
- R10: A return pulse restores the most recently pushed mode. Nested saves come back in last-in, first-out order, up to DEPTH levels.
- R11: When accept and return pulses arrive in the same cycle, the accept is carried out and the return is ignored.
- R12: An accept with a full stack still forces active mode but saves nothing. A return with an empty stack leaves the mode at 0000.
- R13: A gate change made at edge k first shows on the gated clock at edge k+1. During the high phase that follows edge k, the clock keeps its previous state.
- R14: With no write, accept or return, the mode bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock; all gated clocks derive from it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load the mode bits from `mode_bits_i` |
| mode_bits_i | input | 4 | New mode bits: {sub-clock off, DCO gen off, osc off, core off} |
| irq_take_i | input | 1 | Interrupt accepted pulse |
| irq_ret_i | input | 1 | Return from interrupt pulse |
| dco_src_i | input | 1 | High when the DCO feeds the main clock in active mode |
| mode_o | output | 4 | Current mode bits |
| cpu_run_o | output | 1 | Core run enable |
| mclk_o | output | 1 | Gated main clock |
| smclk_o | output | 1 | Gated sub-main clock |
| aclk_o | output | 1 | Gated auxiliary clock |
| dcogen_en_o | output | 1 | DCO DC generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |

## Verification
An interrupt accept can land in the same cycle as a mode write (software entering sleep) or as a return pulse (a back-to-back handler exit). The bench drives both pairs on a single falling edge. For the first pair, the later return must bring back the value just written and not the value held before the write. For the second pair, the mode must read active after the edge, and one more return must restore the pre-accept depth, which shows that the push happened and the pop did not. A stack overflow and an empty-stack return round out the ordering cases.

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl #(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [3:0] mode_bits_i,
  input  logic       irq_take_i,
  input  logic       irq_ret_i,
  input  logic       dco_src_i,
  output logic [3:0] mode_o,
  output logic       cpu_run_o,
  output logic       mclk_o,
  output logic       smclk_o,
  output logic       aclk_o,
  output logic       dcogen_en_o,
  output logic       xtal_en_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SPW-1:0] FULL = SPW'(DEPTH);

  logic [3:0]     mode_q;
  logic [3:0]     stk_q [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [3:0]     push_val;
  logic [2:0]     gate_en, gate_lat;
  logic           full, empty;

  assign full     = (sp_q == FULL);
  assign empty    = (sp_q == '0);
  assign push_val = mode_we_i ? mode_bits_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      sp_q   <= '0;
    end else if (irq_take_i) begin
      mode_q <= '0;
      if (!full) sp_q <= sp_q + 1'b1;
    end else if (irq_ret_i) begin
      if (!empty) begin
        mode_q <= stk_q[IW'(sp_q - 1'b1)];
        sp_q   <= sp_q - 1'b1;
      end else begin
        mode_q <= '0;
      end
    end else if (mode_we_i) begin
      mode_q <= mode_bits_i;
    end
  end

  always_ff @(posedge clk_i)
    if (irq_take_i && !full) stk_q[IW'(sp_q)] <= push_val;

  // {sub-main, main, auxiliary}
  assign gate_en = {~mode_q[3], ~mode_q[0], ~mode_q[1]};

  always_latch
    if (!clk_i) gate_lat <= gate_en;

  assign smclk_o     = clk_i & gate_lat[2];
  assign mclk_o      = clk_i & gate_lat[1];
  assign aclk_o      = clk_i & gate_lat[0];
  assign mode_o      = mode_q;
  assign cpu_run_o   = ~mode_q[0];
  assign xtal_en_o   = ~mode_q[1];
  assign dcogen_en_o = ~mode_q[2] | (dco_src_i & ~mode_q[3]);
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_we_i,
  input logic [3:0] mode_bits_i,
  input logic       irq_take_i,
  input logic       irq_ret_i,
  input logic [3:0] mode_o,
  input logic       cpu_run_o,
  input logic       dcogen_en_o,
  input logic       xtal_en_o
);
  AST_TAKE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> (mode_o == 4'h0 && cpu_run_o)); // R9
  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !irq_take_i && !irq_ret_i) |=> mode_o == $past(mode_bits_i)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_we_i && !irq_take_i && !irq_ret_i) |=> $stable(mode_o)); // R14
  AST_DEEP_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'hF) |-> (!xtal_en_o && !dcogen_en_o && !cpu_run_o)); // R8
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk chk_i (.*);

// File: tb/lpm_clk_ctrl_tb_top.sv
`timescale 1ns/100ps
module lpm_clk_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, take = 0, ret = 0, dco = 0;
  logic [3:0] bits = 0;
  logic [3:0] mode;
  logic cpu_run, mclk, smclk, aclk, dcogen, xtal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(we), .mode_bits_i(bits),
    .irq_take_i(take), .irq_ret_i(ret), .dco_src_i(dco), .mode_o(mode),
    .cpu_run_o(cpu_run), .mclk_o(mclk), .smclk_o(smclk), .aclk_o(aclk),
    .dcogen_en_o(dcogen), .xtal_en_o(xtal));

  // {mode[3:0], dco, cpu, mclk, smclk, aclk, dcogen, xtal}
  localparam logic [10:0] VEC [12] = '{
    {4'b0000, 1'b0, 6'b111111}, {4'b0000, 1'b1, 6'b111111},
    {4'b0001, 1'b0, 6'b001111}, {4'b0001, 1'b1, 6'b001111},
    {4'b0101, 1'b0, 6'b001101}, {4'b0101, 1'b1, 6'b001111},
    {4'b1001, 1'b0, 6'b000111}, {4'b1001, 1'b1, 6'b000111},
    {4'b1101, 1'b0, 6'b000101}, {4'b1101, 1'b1, 6'b000101},
    {4'b1111, 1'b0, 6'b000000}, {4'b1111, 1'b1, 6'b000000}};
  localparam string VREQ [6] = '{"R3", "R4", "R5", "R6", "R7", "R8"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] b, input logic t, input logic r);
    @(negedge clk); we = w; bits = b; take = t; ret = r;
    @(negedge clk); we = 0; take = 0; ret = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", {4'h0, mode}, 8'h00);
    chk("R1 reset levels", {5'h0, cpu_run, dcogen, xtal}, 8'h07);
    @(posedge clk); #1;
    chk("R1 reset clocks", {5'h0, mclk, smclk, aclk}, 8'h07);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {4'h0, mode}, 8'h00);

    // R13: edge-k change shows on the gated clock only at edge k+1
    @(negedge clk); we = 1; bits = 4'b0001;
    @(posedge clk); #1;
    chk("R13 old pulse kept", {7'h0, mclk}, 8'h01);
    @(negedge clk); we = 0;
    @(posedge clk); #1;
    chk("R13 new gate", {7'h0, mclk}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      dco = VEC[i][6];
      step(1, VEC[i][10:7], 0, 0);
      chk({"R2 ", VREQ[i/2]}, {4'h0, mode}, {4'h0, VEC[i][10:7]});
      chk(VREQ[i/2], {5'h0, cpu_run, dcogen, xtal},
          {5'h0, VEC[i][5], VEC[i][1], VEC[i][0]});
      @(posedge clk); #1;
      chk({VREQ[i/2], " clk"}, {5'h0, mclk, smclk, aclk},
          {5'h0, VEC[i][4], VEC[i][3], VEC[i][2]});
    end

    dco = 0;
    step(1, 4'b1101, 0, 0);
    repeat (3) @(negedge clk);
    chk("R14 hold", {4'h0, mode}, 8'h0D);
    step(0, 4'b0000, 1, 0);
    chk("R9 wake", {3'h0, mode, cpu_run}, 8'h01);
    @(posedge clk); #1;
    chk("R9 wake clocks", {5'h0, mclk, smclk, aclk}, 8'h07);
    step(0, 4'b0000, 0, 1);
    chk("R10 restore", {4'h0, mode}, 8'h0D);

    // nesting plus write in the same cycle as an accept
    step(1, 4'b0001, 0, 0);
    step(0, 4'b0000, 1, 0);
    step(1, 4'b1001, 1, 0);
    chk("R9 write+take", {4'h0, mode}, 8'h00);
    step(0, 4'b0000, 0, 1);
    chk("R9 written pushed", {4'h0, mode}, 8'h09);
    step(0, 4'b0000, 0, 1);
    chk("R10 LIFO", {4'h0, mode}, 8'h01);

    // R11 accept and return together
    step(0, 4'b0000, 1, 1);
    chk("R11 take wins", {4'h0, mode}, 8'h00);
    step(0, 4'b0000, 0, 1);
    chk("R11 ret ignored", {4'h0, mode}, 8'h01);

    // R12 overflow and underflow
    step(1, 4'b0001, 1, 0);
    step(1, 4'b0101, 1, 0);
    step(1, 4'b1001, 1, 0);
    step(1, 4'b1101, 1, 0);
    step(1, 4'b1111, 1, 0);
    chk("R12 full take", {4'h0, mode}, 8'h00);
    step(0, 4'b0000, 0, 1);
    chk("R12 dropped", {4'h0, mode}, 8'h0D);
    step(0, 4'b0000, 0, 1);
    chk("R10 pop2", {4'h0, mode}, 8'h09);
    step(0, 4'b0000, 0, 1);
    chk("R10 pop3", {4'h0, mode}, 8'h05);
    step(0, 4'b0000, 0, 1);
    chk("R10 pop4", {4'h0, mode}, 8'h01);
    step(0, 4'b0000, 0, 1);
    chk("R12 empty ret", {4'h0, mode}, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule